// File: doc/BRIEF.md
# Receive Descriptor Base Pointer Control

This block keeps the starting address of a receive descriptor list for a DMA engine. It also tracks the working descriptor pointer that the engine walks through. Software programs the base through a plain register port: a write enable, write data and a combinational readback. A run bit, taken from the engine's operation-mode control, starts and stops reception.

The base can be changed only while reception is stopped. When the run bit rises, the working pointer loads the new base if the base was rewritten during the stop. If it was not rewritten, the pointer resumes from the address where it stopped. While running, each one-cycle advance strobe from the DMA moves the pointer forward by one descriptor.

All addresses are aligned to the data bus width. The low address bits that fall within one bus word are never stored and always read as zero.

Top module: `rx_desc_base_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the readback, the working pointer and the pending-update flag are all zero, and the block is in the stopped state.
- R2: The readback shows the stored base with its low bits forced to zero. The number of cleared bits is 2 for BUS_W=32, 3 for BUS_W=64 and 4 for BUS_W=128. Written values in those bits have no effect.
- R3: A base write is accepted only in a cycle where `run_en` is 0. A write in a cycle with `run_en` at 1 leaves the readback unchanged.
- R4: A start cycle is a cycle where `run_en` is 1 and was 0 in the previous cycle. If at least one write was accepted since the last start cycle, the working pointer equals the stored base one cycle after the start cycle.
- R5: In a start cycle with no accepted write since the previous start, the working pointer keeps its value.
- R6: A start cycle clears the pending-update flag. When several writes are accepted during one stop, the last one is the one loaded at the next start.
- R7: An advance strobe in a cycle where `run_en` is 1 and was also 1 in the previous cycle adds DESC_BYTES to the working pointer. The sum wraps modulo 2^AW.
- R8: An advance strobe has no effect on the pointer when `run_en` is 0 or when the cycle is a start cycle.
- R9: The working pointer never has any of its bus-alignment low bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Base register write strobe |
| reg_wr_data | input | AW | Base register write data |
| reg_rd_data | output | AW | Base register readback, low bits zero |
| run_en | input | 1 | Receive run bit (1 = run, 0 = stop) |
| adv_strobe | input | 1 | One-cycle request to step to the next descriptor |
| cur_desc_ptr | output | AW | Working descriptor pointer |

## Verification
The bench builds the block with BUS_W=64 and DESC_BYTES=24. The three-bit alignment then clears bit 2, which the 32-bit default keeps, so wrong mask sizing shows up at readback. A 24-byte step that is not a power of two exposes any shift-based shortcut in the advance path. Random run toggling makes start cycles, stop cycles and strobes coincide with writes. This reaches the reload-versus-resume decision after single writes, multiple writes and no write.

// File: rtl/rxd_pkg.sv
// Package: shared helpers for the receive descriptor base pointer control.
// Assumes the data bus width is one of 32, 64 or 128; any other value is
// treated as 32.
package rxd_pkg;

    // Number of low address bits cleared for a given bus width in bits.
    function automatic int unsigned align_bits(input int unsigned bus_w);
        case (bus_w)
            128:     return 4;
            64:      return 3;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/rxd_run_track.sv
// Module: rxd_run_track
// Registers the run bit to find start cycles (0 -> 1) and qualifies the
// DMA advance strobe. A strobe counts only when the run bit is high in this
// cycle and was high in the previous one.
// Assumes run_en is synchronous to clk.
module rxd_run_track (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic adv_strobe,
    output logic start_pulse,
    output logic adv_ok
);

    logic run_q;

    // Keep the previous cycle's run bit; stopped out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_en;
    end

    // Decode the start edge and the qualified advance.
    always_comb begin
        start_pulse = run_en & ~run_q;
        adv_ok      = adv_strobe & run_en & run_q;
    end

    // R8
    adv_in_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> !adv_ok);

endmodule

// File: rtl/rxd_base_reg.sv
// Module: rxd_base_reg
// Holds the descriptor list base. Only the bits above the bus alignment are
// stored. Writes are accepted only while the run bit is 0. Every accepted
// write sets a sticky pending flag, and the next start cycle clears it.
// Assumes start_pulse can only be high while run_en is high.
module rxd_base_reg #(
    parameter int AW    = 32,
    parameter int BUS_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          run_en,
    input  logic          start_pulse,
    output logic [AW-1:0] base,
    output logic          pending
);

    localparam int LOW = int'(rxd_pkg::align_bits(BUS_W));

    logic [AW-1:LOW] hi_q;
    logic            pend_q;
    logic            wr_ok;

    // A write counts only while reception is stopped.
    always_comb wr_ok = wr_en & ~run_en;

    // Store the upper address bits on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_ok) hi_q <= wr_data[AW-1:LOW];
    end

    // Sticky flag: set by an accepted write, cleared by a start.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= 1'b0;
        else if (wr_ok)        pend_q <= 1'b1;
        else if (start_pulse)  pend_q <= 1'b0;
    end

    always_comb begin
        base    = {hi_q, {LOW{1'b0}}};
        pending = pend_q;
    end

    // R3
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_en) |=> $stable(base));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !pending);

endmodule

// File: rtl/rxd_ptr_unit.sv
// Module: rxd_ptr_unit
// Working descriptor pointer. At a start it either reloads the base (if a
// write is pending) or keeps its value. During a run it steps by DESC_BYTES
// on each qualified advance.
// Assumes DESC_BYTES is a multiple of the bus width in bytes.
module rxd_ptr_unit #(
    parameter int AW         = 32,
    parameter int BUS_W      = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_pulse,
    input  logic          pending,
    input  logic          adv_ok,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr
);

    localparam int            LOW  = int'(rxd_pkg::align_bits(BUS_W));
    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    logic [AW-1:0] ptr_q;

    // Reload, resume or advance the working pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ptr_q <= '0;
        else if (start_pulse && pending)  ptr_q <= base;
        else if (adv_ok)                  ptr_q <= ptr_q + STEP;
    end

    always_comb ptr = ptr_q;

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && pending) |=> (ptr == $past(base)));

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !pending) |=> $stable(ptr));

    // R7
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ok && !start_pulse) |=> (ptr == $past(ptr) + STEP));

    // R9
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[LOW-1:0] == '0);

endmodule

// File: rtl/rx_desc_base_ctrl.sv
// Module: rx_desc_base_ctrl (top)
// Receive descriptor base register plus the working pointer control that
// decides between reload and resume at each start of reception.
// Assumes a single clock domain and BUS_W in {32, 64, 128}.
module rx_desc_base_ctrl #(
    parameter int AW         = 32,
    parameter int BUS_W      = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_data,
    output logic [AW-1:0] reg_rd_data,
    input  logic          run_en,
    input  logic          adv_strobe,
    output logic [AW-1:0] cur_desc_ptr
);

    logic          start_pulse;
    logic          adv_ok;
    logic          pending;
    logic [AW-1:0] base;

    rxd_run_track u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .adv_strobe  (adv_strobe),
        .start_pulse (start_pulse),
        .adv_ok      (adv_ok)
    );

    rxd_base_reg #(.AW(AW), .BUS_W(BUS_W)) u_base (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_data     (reg_wr_data),
        .run_en      (run_en),
        .start_pulse (start_pulse),
        .base        (base),
        .pending     (pending)
    );

    rxd_ptr_unit #(.AW(AW), .BUS_W(BUS_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .pending     (pending),
        .adv_ok      (adv_ok),
        .base        (base),
        .ptr         (cur_desc_ptr)
    );

    // Readback is the stored, aligned base.
    always_comb reg_rd_data = base;

    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cur_desc_ptr));

endmodule

// File: tb/rx_desc_base_ctrl_test.sv
module rx_desc_base_ctrl_test;

    localparam int AW = 32;
    localparam int BW = 64;
    localparam int DB = 24;
    localparam logic [AW-1:0] MASK = 32'hFFFF_FFF8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic          run = 1'b0;
    logic          adv = 1'b0;
    logic [AW-1:0] rd_data;
    logic [AW-1:0] ptr;

    int tests = 0;
    int fails = 0;

    // Bench model state.
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_ptr  = '0;
    logic          m_flag = 1'b0;
    logic          m_runq = 1'b0;

    always #5 clk = ~clk;

    rx_desc_base_ctrl #(.AW(AW), .BUS_W(BW), .DESC_BYTES(DB)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
        .reg_rd_data(rd_data), .run_en(run), .adv_strobe(adv),
        .cur_desc_ptr(ptr)
    );

    function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
        return a & MASK;
    endfunction

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p,
            input logic [AW-1:0] b, input logic f, input logic r,
            input logic rq, input logic a);
        if (r && !rq && f) return b;
        if (a && r && rq)  return p + AW'(DB);
        return p;
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] got,
                         input logic [AW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, sample at the next falling edge.
    task automatic step(input logic w, input logic [AW-1:0] d,
                        input logic r, input logic a);
        wr_en = w; wr_data = d; run = r; adv = a;
        @(posedge clk);
        m_ptr = next_ptr(m_ptr, m_base, m_flag, r, m_runq, a);
        if (w && !r) begin
            m_base = align(d);
            m_flag = 1'b1;
        end else if (r && !m_runq) begin
            m_flag = 1'b0;
        end
        m_runq = r;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] held;
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 readback", rd_data, '0);
        check("R1 pointer", ptr, '0);
        rst_n = 1'b1;
        // R8: strobe while stopped does nothing
        step(1'b0, '0, 1'b0, 1'b1);
        check("R8 stopped strobe", ptr, '0);
        // R2: low three bits masked
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check("R2 mask all ones", rd_data, 32'hFFFF_FFF8);
        // R6: last of several writes wins
        step(1'b1, 32'h0000_1004, 1'b0, 1'b0);
        check("R2 bit2 cleared", rd_data, 32'h0000_1000);
        step(1'b1, 32'h0000_2000, 1'b0, 1'b0);
        // R4 start loads base; R8 strobe in start cycle ignored
        step(1'b0, '0, 1'b1, 1'b1);
        check("R4 R6 reload last write", ptr, 32'h0000_2000);
        // R7 advance
        step(1'b0, '0, 1'b1, 1'b1);
        check("R7 first step", ptr, 32'h0000_2018);
        step(1'b0, '0, 1'b1, 1'b1);
        check("R7 second step", ptr, 32'h0000_2030);
        // R3 write while running ignored
        step(1'b1, 32'h0000_9000, 1'b1, 1'b0);
        check("R3 write while running", rd_data, 32'h0000_2000);
        // stop, strobe ignored
        step(1'b0, '0, 1'b0, 1'b1);
        check("R8 stopping cycle", ptr, 32'h0000_2030);
        held = ptr;
        // R5 restart with no write resumes
        step(1'b0, '0, 1'b1, 1'b0);
        check("R5 resume", ptr, held);
        step(1'b0, '0, 1'b1, 1'b1);
        check("R7 after resume", ptr, 32'h0000_2048);
        // R7 wrap
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 32'hFFFF_FFF0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        check("R4 reload high", ptr, 32'hFFFF_FFF0);
        step(1'b0, '0, 1'b1, 1'b1);
        check("R7 wrap", ptr, 32'h0000_0008);
        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic w, r, a;
            logic [AW-1:0] d;
            w = ($urandom % 3) == 0;
            r = ($urandom % 4) != 0 ? run : ~run;
            a = ($urandom % 2) == 0;
            d = $urandom;
            step(w, d, r, a);
            check("R3 R4 R5 R7 random ptr", ptr, m_ptr);
            check("R2 R3 random readback", rd_data, m_base);
            check("R9 random align", ptr & ~MASK, '0);
        end
        // R1 reset mid-run
        rst_n = 1'b0;
        step(1'b0, '0, 1'b0, 1'b0);
        check("R1 re-reset pointer", ptr, '0);
        check("R1 re-reset readback", rd_data, '0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule